// File: doc/BRIEF.md
# Bidirectional Port with Upper-Nibble Change Interrupt

This block is an 8-bit general-purpose I/O port that sits on a small processor-style register bus. Software programs a per-pin direction, loads an output latch, and turns on weak pull-ups for the whole port with one active-low control bit. The pad side receives a per-pin drive value, output enable and pull-up enable. Pin levels come back through a two-flop synchronizer.

The upper four pins can raise a change interrupt. Each such pin that is configured as an input is compared with a snapshot of the port taken at the last port access. Any difference sets a sticky flag, which also drives a wake request for a sleeping core. The flag keeps being set for as long as the difference lasts. A typical handler reads the port, which ends the mismatch, and then clears the flag.

Register map on `bus_addr`: 0 = port data, 1 = direction, 2 = control, 3 = reserved (reads 0, writes ignored). In the control register, bit 7 is the pull-up disable (active-low enable) and bit 0 is the change flag. Writing a 0 to control bit 0 requests a clear. Writing a 1 there has no effect.

Top module: `gpio_chg_port`

## Requirements
- R1: Direction bit i at 1 makes pin i an input (`pin_oe[i]`=0). At 0 it drives the output latch bit (`pin_oe[i]`=1, `pin_out[i]`=latch bit i). The latch is written at address 0 and the direction at address 1, and both take effect one cycle after the write.
- R2: After synchronous reset, direction is 8'hFF, the latch is 0, the snapshot is 0, the flag is clear, and pull-ups are off (control bit 7 = 1).
- R3: Pins 3..0 never affect the flag, and pins 7..4 that are configured as outputs do not affect it either.
- R4: When a synchronized, input-configured pin among 7..4 differs from its snapshot bit, the flag is 1 on the next cycle. A raw pin edge therefore shows on the flag three cycles later.
- R5: While the mismatch lasts the flag is set again every cycle. A clear strobe in the same cycle as a mismatch loses, and a clear strobe with no mismatch drops the flag on the next cycle.
- R6: Any read or write of address 0 reloads the snapshot from the synchronized pins, which ends the mismatch.
- R7: `pin_pu[i]` is 1 exactly when control bit 7 is 0 and direction bit i is 1.
- R8: `wake_req` equals the flag.
- R9: Read data is combinational on `bus_addr`. Address 0 returns the synchronized level for input pins and the latch value for output pins. Address 1 returns the direction. Address 2 returns {pull-up disable, 6'b0, flag}. Address 3 returns 0.
- R10: Pin inputs pass through two flops, so an address-0 read shows a pin change two cycles after it occurs at `pin_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe (affects snapshot on address 0) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pin levels from the pad |
| pin_out | output | 8 | Output drive values |
| pin_oe | output | 8 | Output enables, 1 = driven |
| pin_pu | output | 8 | Weak pull-up enables |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Wake request |

## Verification
The change logic is tried with the following patterns:
- Toggles on the lower nibble only. A flag here would show that the nibble mask is missing.
- Toggles on an upper pin that has been turned to output. A flag here would show that the direction mask is missing.
- A held mismatch with a clear attempt. This separates set-over-clear priority from a plain clear.
- Port reads and port writes that end the mismatch. These confirm the snapshot reload.

A timed pin edge measures synchronizer depth through both the read path and the flag path. A long stretch of random pins and bus operations is compared cycle by cycle against a behavioural model.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int PORT_W    = 8;
    localparam int CHG_LSB   = 4;
    localparam int CHG_W     = PORT_W - CHG_LSB;
    localparam int SYNC_DEPTH = 2;
    localparam int PU_BIT    = 7;
    localparam int FLAG_BIT  = 0;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [PORT_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
        logic              pu_off;
    } port_cfg_t;

    // Mixes synchronized input levels with latch values according to direction
    function automatic logic [PORT_W-1:0] port_view(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] lat,
        input logic [PORT_W-1:0] lvl
    );
        return (dir & lvl) | (~dir & lat);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_chg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    output port_cfg_t cfg,
    output logic      data_access,
    output logic      flag_clr
);
    port_cfg_t cfg_q;

    logic hit_data, hit_dir, hit_ctrl;

    always_comb begin
        hit_data    = (req.sel == REG_DATA);
        hit_dir     = (req.sel == REG_DIR);
        hit_ctrl    = (req.sel == REG_CTRL);
        data_access = hit_data && (req.rd || req.wr);
        flag_clr    = req.wr && hit_ctrl && !req.wdata[FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.dir    <= '1;
            cfg_q.lat    <= '0;
            cfg_q.pu_off <= 1'b1;
        end else if (req.wr) begin
            if (hit_data) cfg_q.lat    <= req.wdata;
            if (hit_dir)  cfg_q.dir    <= req.wdata;
            if (hit_ctrl) cfg_q.pu_off <= req.wdata[PU_BIT];
        end
    end

    assign cfg = cfg_q;

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == REG_DIR) |=> (cfg.dir == $past(req.wdata))); // R1

    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == REG_DATA) |=> (cfg.lat == $past(req.wdata))); // R1
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det
    import gpio_chg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] lvl,
    input  logic [PORT_W-1:0] dir,
    input  logic              snap_load,
    input  logic              flag_clr,
    output logic              flag
);
    logic [CHG_W-1:0] snap_q;
    logic [CHG_W-1:0] diff;
    logic             mismatch;
    logic             flag_q;

    genvar i;
    generate
        for (i = 0; i < CHG_W; i++) begin : g_cmp
            assign diff[i] = dir[CHG_LSB+i] && (lvl[CHG_LSB+i] != snap_q[i]);
        end
    endgenerate

    assign mismatch = |diff;

    always_ff @(posedge clk) begin
        if (rst)            snap_q <= '0;
        else if (snap_load) snap_q <= lvl[PORT_W-1:CHG_LSB];
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (mismatch) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (mismatch && flag_clr) |=> flag); // R5

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!mismatch && flag_clr) |=> !flag); // R5

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!mismatch && !flag) |=> !flag); // R4

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        snap_load |=> (snap_q == $past(lvl[PORT_W-1:CHG_LSB]))); // R6
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu,
    output logic              chg_flag,
    output logic              wake_req
);
    bus_req_t          req;
    port_cfg_t         cfg;
    logic [PORT_W-1:0] lvl;
    logic              data_access;
    logic              flag_clr;
    logic              flag;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.sel   = reg_sel_e'(bus_addr);
        req.wdata = bus_wdata;
    end

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    gpio_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .cfg         (cfg),
        .data_access (data_access),
        .flag_clr    (flag_clr)
    );

    gpio_chg_det u_det (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl),
        .dir       (cfg.dir),
        .snap_load (data_access),
        .flag_clr  (flag_clr),
        .flag      (flag)
    );

    always_comb begin
        unique case (req.sel)
            REG_DATA: bus_rdata = port_view(cfg.dir, cfg.lat, lvl);
            REG_DIR:  bus_rdata = cfg.dir;
            REG_CTRL: begin
                bus_rdata           = '0;
                bus_rdata[PU_BIT]   = cfg.pu_off;
                bus_rdata[FLAG_BIT] = flag;
            end
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out  = cfg.lat;
    assign pin_oe   = ~cfg.dir;
    assign pin_pu   = cfg.pu_off ? '0 : cfg.dir;
    assign chg_flag = flag;
    assign wake_req = flag;

    AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0); // R7

    AST_WAKE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_flag) |-> wake_req); // R8
endmodule

// File: tb/gpio_chg_port_tb.sv
`timescale 1ns/1ps
module gpio_chg_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] bus_rdata, pin_out, pin_oe, pin_pu;
    logic       chg_flag, wake_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_chg_port u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .chg_flag(chg_flag), .wake_req(wake_req)
    );

    // behavioural reference state
    logic [7:0] m_dir, m_lat, m_p1, m_p2;
    logic [3:0] m_snap;
    logic       m_flag, m_puoff;

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 8'hFF; m_lat = 0; m_p1 = 0; m_p2 = 0;
            m_snap = 0; m_flag = 0; m_puoff = 1;
        end else begin
            bit diff;
            diff = 0;
            for (int k = 4; k < 8; k++)
                if (m_dir[k] && (m_p2[k] !== m_snap[k-4])) diff = 1;
            if (diff) m_flag = 1;
            else if (bus_wr && bus_addr == 2 && !bus_wdata[0]) m_flag = 0;
            if ((bus_rd || bus_wr) && bus_addr == 0) m_snap = m_p2[7:4];
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_lat = bus_wdata;
                    2'd1: m_dir = bus_wdata;
                    2'd2: m_puoff = bus_wdata[7];
                    default: ;
                endcase
            end
            m_p2 = m_p1;
            m_p1 = pin_in;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] exp_rd, exp_pu;
            case (bus_addr)
                2'd0: exp_rd = 0;
                default: exp_rd = 0;
            endcase
            for (int k = 0; k < 8; k++) begin
                exp_rd[k] = m_dir[k] ? m_p2[k] : m_lat[k];
                exp_pu[k] = !m_puoff && m_dir[k];
            end
            if (bus_addr == 1) exp_rd = m_dir;
            else if (bus_addr == 2) exp_rd = {m_puoff, 6'b0, m_flag};
            else if (bus_addr == 3) exp_rd = 0;
            chk("R1", "pin_oe", pin_oe, ~m_dir);
            chk("R1", "pin_out", pin_out, m_lat);
            chk("R7", "pin_pu", pin_pu, exp_pu);
            chk("R4", "chg_flag", {7'b0, chg_flag}, {7'b0, m_flag});
            chk("R8", "wake_req", {7'b0, wake_req}, {7'b0, m_flag});
            chk("R9", "bus_rdata", bus_rdata, exp_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic op(input logic rd, input logic wr, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); #1;
        pin_in = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R2: reset state
        chk("R2", "pin_oe", pin_oe, 8'h00);
        chk("R2", "pin_pu", pin_pu, 8'h00);
        chk("R2", "flag", {7'b0, chg_flag}, 8'h00);
        bus_addr = 2;
        @(negedge clk);
        chk("R2", "ctrl", bus_rdata, 8'h80);
        bus_addr = 0;

        // R4 / R10: edge on pin 5 reaches read path after 2, flag after 3
        set_pins(8'h20);
        chk("R10", "rd before sync", bus_rdata, 8'h00);
        idle(1);
        chk("R10", "rd after 1", bus_rdata, 8'h00);
        idle(1);
        chk("R10", "rd after 2", bus_rdata, 8'h20);
        chk("R4", "flag not yet", {7'b0, chg_flag}, 8'h00);
        idle(1);
        chk("R4", "flag after 3", {7'b0, chg_flag}, 8'h01);

        // R5: clear while mismatch persists is lost
        op(0, 1, 2, 8'h80);
        chk("R5", "flag held", {7'b0, chg_flag}, 8'h01);

        // R6: port read ends mismatch, clear then works
        op(1, 0, 0, 8'h00);
        op(0, 1, 2, 8'h80);
        chk("R6", "flag cleared after read", {7'b0, chg_flag}, 8'h00);

        // R3: lower nibble ignored
        set_pins(8'h2F);
        idle(5);
        chk("R3", "low nibble", {7'b0, chg_flag}, 8'h00);

        // R3 / R1 / R7: pin 7 as output is masked
        op(0, 1, 1, 8'h7F);
        op(0, 1, 2, 8'h00);
        op(0, 1, 0, 8'h81);
        set_pins(8'hAF);
        idle(5);
        chk("R3", "output masked", {7'b0, chg_flag}, 8'h00);
        chk("R1", "oe", pin_oe, 8'h80);
        chk("R1", "out", pin_out, 8'h81);
        chk("R7", "pu", pin_pu, 8'h7F);
        bus_addr = 0;
        @(negedge clk);
        chk("R9", "mixed read", bus_rdata, 8'hAF);

        // R6: pin 7 back to input -> mismatch; port write ends it
        op(0, 1, 1, 8'hFF);
        idle(2);
        chk("R4", "flag from pin7", {7'b0, chg_flag}, 8'h01);
        op(0, 1, 0, 8'h00);
        op(0, 1, 2, 8'h00);
        chk("R6", "flag cleared after write", {7'b0, chg_flag}, 8'h00);
        op(0, 1, 2, 8'h01);
        bus_addr = 3;
        @(negedge clk);
        chk("R9", "reserved", bus_rdata, 8'h00);

        // random phase
        for (int n = 0; n < 600; n++) begin
            @(negedge clk); #1;
            if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
            bus_addr = 2'($urandom);
            bus_rd = ($urandom_range(0, 3) == 0);
            bus_wr = ($urandom_range(0, 4) == 0);
            bus_wdata = 8'($urandom);
        end
        @(negedge clk); #1;
        bus_rd = 0; bus_wr = 0;
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule